// File: doc/BRIEF.md
# E1 Timeslot-Zero Spare-Bit Data Link Port

This block carries a low-rate user data link in the spare bits of timeslot zero in E1 frames. Only the timeslot-zero byte of the frames that do not hold the alignment word has spare bits, and that frame comes every other frame. In that byte the last five bit cells are the spare bits Sa4 to Sa8. A five-bit select word chooses which of them belong to the link. Each chosen bit adds 4 kb/s, so the link runs at 4, 8, 12, 16 or 20 kb/s.

The block runs on the 2.048 MHz bit clock. A framer, not part of this block, supplies a timeslot-zero flag, a frame-parity flag and a bit counter for each direction. On transmit, the block raises a gated clock `tx_dl_clk` for one bit period in each selected cell. It samples the controller's serial bit `tx_dl` at the rising edge that ends that period and writes it into the outgoing line stream in place of the upstream bit, whatever the upstream bit was. On receive, it copies each selected line bit to `rx_dl` and raises `rx_dl_clk` for one period aligned with it. The link is timed by these gated clocks, so it has no valid/ready handshake: the controller must follow the pulses.

A new select word is held as pending and moves into use at the next frame boundary that has spare bits, on each side separately. A frame therefore never uses a mix of the old and new selections.

Top module: `e1_sa_link`

## Requirements
- R1: While `rst_n` is low, `tx_line_out`, `tx_dl_clk`, `rx_dl` and `rx_dl_clk` are 0, and both active selections are 0.
- R2: The bit counter counts 7 down to 0 within timeslot zero. `tx_dl_clk` is 1 in exactly the cycles where `tx_ts0`=1, `tx_nfas`=1, `tx_bit_idx`=k with k in 0..4, and bit k of the active transmit selection is 1. Select bit 4 is Sa4 (the first spare cell) and bit 0 is Sa8, so link bits go out in Sa4-to-Sa8 order.
- R3: One cycle after a cycle with `tx_dl_clk`=1, `tx_line_out` equals the `tx_dl` of that cycle. After any other cycle it equals the `tx_line_in` of that cycle.
- R4: No clock pulse on either side in frames with parity flag 0, outside timeslot zero, or at bit counts 7 to 5.
- R5: While the active selection is zero, no clock pulses occur on that side, and the transmit line passes through with a one-cycle delay.
- R6: A select write (`sel_wr`=1) becomes active on a side at the cycle after that side's next boundary, where a boundary is timeslot zero, parity 1, bit count 7. A write in the boundary cycle itself is used by that boundary.
- R7: One cycle after a selected receive cell, `rx_dl_clk`=1 and `rx_dl` equals the line bit of that cell. After any other cycle `rx_dl_clk`=0 and `rx_dl` holds its value.
- R8: Each transmit frame with parity 1 produces as many clock pulses as there are ones in the selection active in that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 2.048 MHz bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_wr | input | 1 | Write strobe for the select word |
| sel_data | input | 5 | Select word; bit 4 = Sa4 ... bit 0 = Sa8 |
| tx_ts0 | input | 1 | Transmit framer: current bit is in timeslot zero |
| tx_nfas | input | 1 | Transmit framer: current frame has spare bits (1) |
| tx_bit_idx | input | 3 | Transmit framer: bit in timeslot, 7 first, 0 last |
| tx_line_in | input | 1 | Upstream transmit line bit |
| tx_dl | input | 1 | Data link bit from the controller |
| tx_line_out | output | 1 | Transmit line bit with link bits inserted, one cycle later |
| tx_dl_clk | output | 1 | Gated transmit link clock |
| rx_ts0 | input | 1 | Receive framer: current bit is in timeslot zero |
| rx_nfas | input | 1 | Receive framer: current frame has spare bits (1) |
| rx_bit_idx | input | 3 | Receive framer: bit in timeslot, 7 first, 0 last |
| rx_line_in | input | 1 | Received line bit |
| rx_dl | output | 1 | Extracted link bit, held between pulses |
| rx_dl_clk | output | 1 | Gated receive link clock aligned with rx_dl |

## Verification
The assertions check every cycle that each transmit pulse falls in a frame with spare bits and timeslot zero, and that the line output takes the sampled link bit after a pulse. They also check that the receive output follows or holds as the pulses dictate, and that an active selection changes only after a boundary. Only the bench scenarios can show that the pulses land in the right cells for each select pattern and that a write in the middle of a frame is held back for a full frame. The same goes for writes at the boundary cycle and for the pulse count per frame.

// File: rtl/e1_sa_pkg.sv
package e1_sa_pkg;
  localparam int SA_COUNT = 5;
  localparam int BIT_W    = 3;
  typedef logic [SA_COUNT-1:0] sa_sel_t;
endpackage

// File: rtl/sa_cell_decode.sv
module sa_cell_decode #(
  parameter int SA_COUNT = e1_sa_pkg::SA_COUNT,
  parameter int BIT_W    = e1_sa_pkg::BIT_W
) (
  input  logic                ts0,
  input  logic                nfas,
  input  logic [BIT_W-1:0]    bit_idx,
  input  logic [SA_COUNT-1:0] sel,
  output logic                hit,
  output logic                boundary
);
  localparam logic [BIT_W-1:0] LAST_SA   = BIT_W'(SA_COUNT - 1);
  localparam logic [BIT_W-1:0] FIRST_BIT = {BIT_W{1'b1}};

  logic in_sa;
  assign in_sa = ts0 && nfas && (bit_idx <= LAST_SA);

  always_comb begin
    hit = 1'b0;
    for (int k = 0; k < SA_COUNT; k++) begin
      if (in_sa && (bit_idx == BIT_W'(k)) && sel[k]) hit = 1'b1;
    end
  end

  assign boundary = ts0 && nfas && (bit_idx == FIRST_BIT);
endmodule

// File: rtl/sa_sel_reg.sv
module sa_sel_reg #(
  parameter int SA_COUNT = e1_sa_pkg::SA_COUNT
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [SA_COUNT-1:0] wdata,
  input  logic                boundary,
  output logic [SA_COUNT-1:0] act
);
  logic [SA_COUNT-1:0] pend;
  logic [SA_COUNT-1:0] next_val;

  assign next_val = wr ? wdata : pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      act  <= '0;
    end else begin
      pend <= next_val;
      if (boundary) act <= next_val;
    end
  end

  // R6
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> $stable(act));
endmodule

// File: rtl/sa_tx_insert.sv
module sa_tx_insert (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic dl_bit,
  input  logic line_in,
  output logic line_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_out <= 1'b0;
    else        line_out <= hit ? dl_bit : line_in;
  end

  // R3
  tx_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (line_out == $past(dl_bit)));
  // R3
  tx_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> (line_out == $past(line_in)));
endmodule

// File: rtl/sa_rx_extract.sv
module sa_rx_extract (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic line_in,
  output logic dl_bit,
  output logic dl_clk
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dl_bit <= 1'b0;
      dl_clk <= 1'b0;
    end else begin
      dl_clk <= hit;
      if (hit) dl_bit <= line_in;
    end
  end

  // R7
  rx_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (dl_clk && (dl_bit == $past(line_in))));
  // R7
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> (!dl_clk && $stable(dl_bit)));
endmodule

// File: rtl/e1_sa_link.sv
module e1_sa_link #(
  parameter int SA_COUNT = e1_sa_pkg::SA_COUNT,
  parameter int BIT_W    = e1_sa_pkg::BIT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sel_wr,
  input  logic [SA_COUNT-1:0] sel_data,
  input  logic                tx_ts0,
  input  logic                tx_nfas,
  input  logic [BIT_W-1:0]    tx_bit_idx,
  input  logic                tx_line_in,
  input  logic                tx_dl,
  output logic                tx_line_out,
  output logic                tx_dl_clk,
  input  logic                rx_ts0,
  input  logic                rx_nfas,
  input  logic [BIT_W-1:0]    rx_bit_idx,
  input  logic                rx_line_in,
  output logic                rx_dl,
  output logic                rx_dl_clk
);
  logic [SA_COUNT-1:0] tx_act, rx_act;
  logic tx_hit, tx_bnd, rx_hit, rx_bnd;

  sa_cell_decode #(.SA_COUNT(SA_COUNT), .BIT_W(BIT_W)) u_tx_dec (
    .ts0(tx_ts0), .nfas(tx_nfas), .bit_idx(tx_bit_idx), .sel(tx_act),
    .hit(tx_hit), .boundary(tx_bnd));

  sa_cell_decode #(.SA_COUNT(SA_COUNT), .BIT_W(BIT_W)) u_rx_dec (
    .ts0(rx_ts0), .nfas(rx_nfas), .bit_idx(rx_bit_idx), .sel(rx_act),
    .hit(rx_hit), .boundary(rx_bnd));

  sa_sel_reg #(.SA_COUNT(SA_COUNT)) u_tx_sel (
    .clk(clk), .rst_n(rst_n), .wr(sel_wr), .wdata(sel_data),
    .boundary(tx_bnd), .act(tx_act));

  sa_sel_reg #(.SA_COUNT(SA_COUNT)) u_rx_sel (
    .clk(clk), .rst_n(rst_n), .wr(sel_wr), .wdata(sel_data),
    .boundary(rx_bnd), .act(rx_act));

  sa_tx_insert u_tx (
    .clk(clk), .rst_n(rst_n), .hit(tx_hit), .dl_bit(tx_dl),
    .line_in(tx_line_in), .line_out(tx_line_out));

  sa_rx_extract u_rx (
    .clk(clk), .rst_n(rst_n), .hit(rx_hit), .line_in(rx_line_in),
    .dl_bit(rx_dl), .dl_clk(rx_dl_clk));

  assign tx_dl_clk = tx_hit;

  // R4
  tx_frame_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_dl_clk |-> (tx_ts0 && tx_nfas));
  // R5
  tx_zero_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_act == '0) |-> !tx_dl_clk);
endmodule

// File: tb/test_e1_sa_link.sv
module test_e1_sa_link;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, sel_wr, tx_ts0, tx_nfas, tx_line_in, tx_dl;
  logic rx_ts0, rx_nfas, rx_line_in;
  logic [4:0] sel_data;
  logic [2:0] tx_bit_idx, rx_bit_idx;
  logic tx_line_out, tx_dl_clk, rx_dl, rx_dl_clk;

  e1_sa_link i_e1_sa_link (
    .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_data(sel_data),
    .tx_ts0(tx_ts0), .tx_nfas(tx_nfas), .tx_bit_idx(tx_bit_idx),
    .tx_line_in(tx_line_in), .tx_dl(tx_dl), .tx_line_out(tx_line_out),
    .tx_dl_clk(tx_dl_clk), .rx_ts0(rx_ts0), .rx_nfas(rx_nfas),
    .rx_bit_idx(rx_bit_idx), .rx_line_in(rx_line_in), .rx_dl(rx_dl),
    .rx_dl_clk(rx_dl_clk));

  int checks = 0;
  int errors = 0;
  int t = 0;
  int m_pend = 0, m_tx_act = 0, m_rx_act = 0, m_frame_sel = 0;
  int frame_cnt = 0;
  int frame_log[$];
  int exp_tx_out = 0, exp_rx_clk = 0, exp_rx_dl = 0;
  bit done = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (cycle %0d)", tag, act, exp, t);
    end
  endtask

  function automatic int ones(input int v);
    int n = 0;
    for (int k = 0; k < 5; k++) if (v[k]) n++;
    return n;
  endfunction

  function automatic bit model_hit(input int pos, input int sel);
    int b = 7 - (pos % 8);
    if ((pos % 256) >= 8) return 0;
    if (((pos / 256) % 2) == 0) return 0;
    if (b > 4) return 0;
    return sel[b];
  endfunction

  task automatic step(input bit wr, input int data);
    int tp, rp, tb;
    bit th, rh, tbnd, rbnd;
    string tag;
    @(negedge clk);
    chk("R3 tx_line_out", tx_line_out, exp_tx_out);
    chk("R7 rx_dl_clk", rx_dl_clk, exp_rx_clk);
    chk("R7 rx_dl", rx_dl, exp_rx_dl);
    tp = t;
    rp = t + 100;
    if ((tp % 256) == 0) frame_cnt = 0;
    tx_ts0 = (tp % 256) < 8;
    tx_nfas = ((tp / 256) % 2) == 1;
    tx_bit_idx = 3'(7 - (tp % 8));
    rx_ts0 = (rp % 256) < 8;
    rx_nfas = ((rp / 256) % 2) == 1;
    rx_bit_idx = 3'(7 - (rp % 8));
    tx_line_in = 1'($urandom_range(0, 1));
    tx_dl = 1'($urandom_range(0, 1));
    rx_line_in = 1'($urandom_range(0, 1));
    sel_wr = wr;
    sel_data = 5'(data);
    #1;
    th = model_hit(tp, m_tx_act);
    rh = model_hit(rp, m_rx_act);
    tb = 7 - (tp % 8);
    if (m_tx_act == 0) tag = "R5 tx_dl_clk";
    else if (!tx_nfas || !tx_ts0 || tb > 4) tag = "R4 tx_dl_clk";
    else tag = "R2 tx_dl_clk";
    chk(tag, tx_dl_clk, th);
    exp_tx_out = th ? tx_dl : tx_line_in;
    exp_rx_clk = rh;
    if (rh) exp_rx_dl = rx_line_in;
    if (th) frame_cnt++;
    tbnd = ((tp % 512) == 256);
    rbnd = ((rp % 512) == 256);
    if (tbnd) begin
      m_tx_act = wr ? data : m_pend;
      m_frame_sel = m_tx_act;
    end
    if (rbnd) m_rx_act = wr ? data : m_pend;
    if (wr) m_pend = data;
    if ((tp % 256) == 255) begin
      if (tx_nfas) begin
        chk("R8 pulses per frame", frame_cnt, ones(m_frame_sel));
        frame_log.push_back(frame_cnt);
      end else begin
        chk("R4 pulses in alignment frame", frame_cnt, 0);
      end
    end
    t++;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 0);
  endtask

  task automatic run_until(input int m);
    while ((t % 512) != m) step(1'b0, 0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    sel_wr = 1'b0; sel_data = '0;
    tx_ts0 = 0; tx_nfas = 0; tx_bit_idx = '0; tx_line_in = 0; tx_dl = 0;
    rx_ts0 = 0; rx_nfas = 0; rx_bit_idx = '0; rx_line_in = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset tx_line_out", tx_line_out, 0);
    chk("R1 reset tx_dl_clk", tx_dl_clk, 0);
    chk("R1 reset rx_dl", rx_dl, 0);
    chk("R1 reset rx_dl_clk", rx_dl_clk, 0);
    rst_n = 1'b1;

    run(1024);                 // R5: zero selection
    step(1'b1, 5'b10000);      // Sa4 only
    run(1024);
    step(1'b1, 5'b11111);      // all five
    run(1024);
    step(1'b1, 5'b01010);
    run(1024);

    // R6: write in the middle of the spare-bit cells is held back
    run_until(261);
    step(1'b1, 5'b00111);
    run_until(0);
    chk("R6 frame of mid-frame write", frame_log[$], 2);
    run_until(256);
    run_until(0);
    chk("R6 frame after write", frame_log[$], 3);

    // R6: write in the boundary cycle is used at once
    run_until(256);
    step(1'b1, 5'b11000);
    run_until(0);
    chk("R6 boundary-cycle write", frame_log[$], 2);
    run(1024);

    step(1'b1, 5'b00001);      // Sa8 only
    run(1024);
    step(1'b1, 5'b00000);      // back to zero, R5
    run(1024);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule